// File: doc/BRIEF.md
# Character Overlay Pixel Generator

This block turns a grid of character codes into a dot-by-dot overlay stream for video. The grid has 12 rows of 24 cells. Each cell holds a character code and a 3-bit colour. On each dot clock the block works out which cell, glyph column and glyph line fall under the current raster position. It sends a font address to a synchronous font memory and, one cycle later, picks the addressed glyph bit. The result is a pixel-valid flag and a colour for that dot.

Each row has its own size mode, which stretches the glyphs horizontally, vertically or both. The whole grid can be moved right in steps of one third of a cell and down in single raster lines. Rows are separated by a programmable number of blank raster lines. Two strobes frame the scan: a horizontal strobe opens each raster line and a vertical strobe opens each field. A host write port loads the cells, the row modes and the placement values.

Top module: `osd_gen`

## Requirements
- R1: While reset is held, and on the first edge after it is held, `pix_valid` and `pix_color` are 0. Reset sets every cell code to 0, every row mode to standard, and the horizontal start, vertical start and row gap to 0. After reset a scanned line shows no pixels.
- R2: The grid is 24 columns by 12 rows. A cell write uses `wr_kind`=0 with `wr_addr` = row*24+column; `wr_data[13:0]` is the code and `wr_data[16:14]` is the colour. A row-mode write uses `wr_kind`=1 with the row number in `wr_addr` and the mode in `wr_data[2:0]`. Every cell, including row 11 column 23, can be displayed.
- R3: `font_addr` is {cell code, 5-bit glyph line}. The font word arrives on `font_data` one clock later. Glyph column g (0 = leftmost) is bit 23-g. Dot x of a raster line (x = 0 at the first dot) appears on the outputs after the (x+2)-th rising edge that follows the edge sampling `hsync`.
- R4: A lit dot carries the 3-bit colour of its cell. `pix_color` is 0 whenever `pix_valid` is 0.
- R5: A cell whose code is 0 never lights a dot.
- R6: Row mode 0 is standard, 1 is double width, 2 is double height, 3 is double width with double height, and 4 is quadruple width with double height. Codes 5 to 7 act as standard. Double width repeats each glyph column twice and quadruple width repeats it four times, giving cells 48 or 96 dots wide.
- R7: In modes 2, 3 and 4 each glyph line is repeated on two raster lines, so the row is 64 lines tall. Otherwise a row is 32 lines tall.
- R8: The horizontal start is written with `wr_kind`=2 into `wr_data[6:0]`, in units of 8 dots. Column 0 of every row starts at dot 8*start, and dots left of it are dark.
- R9: The vertical start (`wr_kind`=3, `wr_data[9:0]`) is the raster line where row 0 begins. The row gap (`wr_data[13:10]`, 0 to 15) is the number of dark lines after each row before the next row begins. Lines above row 0 and below row 11 are dark.
- R10: Dots at x >= 720, and positions past column 23 of a row, are dark even when a stretched row would extend there.
- R11: The raster line number is the count of `hsync` strobes since the last `vsync` strobe, minus one. When `vsync` and `hsync` are sampled in the same cycle, the line that starts is line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync | input | 1 | One-cycle strobe that starts a raster line |
| vsync | input | 1 | One-cycle strobe that starts a field |
| wr_en | input | 1 | Host write enable |
| wr_kind | input | 2 | Write target: 0 cell, 1 row mode, 2 horizontal start, 3 vertical start and gap |
| wr_addr | input | 9 | Cell index or row number |
| wr_data | input | 17 | Write data |
| font_addr | output | 19 | Font memory address {code, glyph line} |
| font_data | input | 24 | Font word, one cycle after the address |
| pix_valid | output | 1 | Dot is part of a lit glyph |
| pix_color | output | 3 | Colour of the lit dot |

## Verification
The line strobe and the field strobe can be sampled in the same cycle. That cycle must both reset the line counter and start a line. The bench provokes this by pulsing both strobes together and then scanning the line that follows. That line must match a model of raster line 0 dot for dot, with the grid placed at vertical start 0. If the design handled the strobes in the wrong priority, the line would come out as the line after 0 or as a far-off line, and its glyph line and colour would differ from the model.

// File: rtl/osd_gen.sv
module osd_gen #(
  parameter int COLS   = 24,
  parameter int ROWS   = 12,
  parameter int CELL_W = 24,
  parameter int CELL_H = 32,
  parameter int CODE_W = 14,
  parameter int LINE_W = 720,
  parameter int VY_W   = 10,
  parameter int GAP_W  = 4,
  parameter int HPOS_W = 7,
  localparam int CELLS     = COLS * ROWS,
  localparam int ADDR_W    = $clog2(CELLS),
  localparam int LINE_BITS = $clog2(CELL_H),
  localparam int WD_W      = CODE_W + 3,
  localparam int HX_W      = $clog2(LINE_W + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hsync,
  input  logic                        vsync,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_kind,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [WD_W-1:0]             wr_data,
  output logic [CODE_W+LINE_BITS-1:0] font_addr,
  input  logic [CELL_W-1:0]           font_data,
  output logic                        pix_valid,
  output logic [2:0]                  pix_color
);
  localparam int ROW_IW = $clog2(ROWS);
  localparam int YS_W   = VY_W + 2;
  localparam int XW     = HX_W + 1;
  localparam int GX_W   = $clog2(CELL_W);
  localparam int THIRD  = CELL_W / 3;

  function automatic logic is_tall(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd3) || (m == 3'd4);
  endfunction

  function automatic logic [1:0] wshift(input logic [2:0] m);
    case (m)
      3'd1, 3'd3: return 2'd1;
      3'd4:       return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  logic [CODE_W-1:0] code_mem [CELLS];
  logic [2:0]        colr_mem [CELLS];
  logic [2:0]        mode_q   [ROWS];
  logic [HPOS_W-1:0] hpos_q;
  logic [VY_W-1:0]   vstart_q;
  logic [GAP_W-1:0]  gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CELLS; i++) begin
        code_mem[i] <= '0;
        colr_mem[i] <= '0;
      end
      for (int r = 0; r < ROWS; r++) mode_q[r] <= '0;
      hpos_q   <= '0;
      vstart_q <= '0;
      gap_q    <= '0;
    end else if (wr_en) begin
      case (wr_kind)
        2'd0: if (wr_addr < ADDR_W'(CELLS)) begin
          code_mem[wr_addr] <= wr_data[CODE_W-1:0];
          colr_mem[wr_addr] <= wr_data[CODE_W+2:CODE_W];
        end
        2'd1: if (wr_addr < ADDR_W'(ROWS)) mode_q[ROW_IW'(wr_addr)] <= wr_data[2:0];
        2'd2: hpos_q <= wr_data[HPOS_W-1:0];
        default: begin
          vstart_q <= wr_data[VY_W-1:0];
          gap_q    <= wr_data[VY_W+GAP_W-1:VY_W];
        end
      endcase
    end
  end

  logic [HX_W-1:0] hx;
  logic [VY_W-1:0] vy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hx <= HX_W'(LINE_W);
      vy <= '1;
    end else begin
      if (hsync)                    hx <= '0;
      else if (hx < HX_W'(LINE_W))  hx <= hx + 1'b1;
      if (vsync && hsync)           vy <= '0;
      else if (vsync)               vy <= '1;
      else if (hsync)               vy <= vy + 1'b1;
    end
  end

  logic [YS_W-1:0] vy_x;
  logic [YS_W-1:0] rtop [ROWS];
  logic [ROWS-1:0] hit;

  assign vy_x    = YS_W'(vy);
  assign rtop[0] = YS_W'(vstart_q);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [YS_W-1:0] rh;
    assign rh     = is_tall(mode_q[r]) ? YS_W'(2 * CELL_H) : YS_W'(CELL_H);
    assign hit[r] = (vy_x >= rtop[r]) && (vy_x < rtop[r] + rh);
    if (r < ROWS - 1) begin : g_next
      assign rtop[r+1] = rtop[r] + rh + YS_W'(gap_q);
    end
  end

  logic              row_hit;
  logic [ROW_IW-1:0] row_idx;
  logic [YS_W-1:0]   row_top;

  always_comb begin
    row_hit = 1'b0;
    row_idx = '0;
    row_top = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        row_hit = 1'b1;
        row_idx = ROW_IW'(r);
        row_top = rtop[r];
      end
    end
  end

  logic [2:0]           row_mode;
  logic [XW-1:0]        xs, rel, u, col, gx;
  logic                 in_x, in_grid, act;
  logic [ADDR_W-1:0]    idx;
  logic [CODE_W-1:0]    cell_code;
  logic [2:0]           cell_col;
  logic [YS_W-1:0]      dy;
  logic [LINE_BITS-1:0] gline;

  assign row_mode  = mode_q[row_idx];
  assign xs        = XW'(hpos_q) * XW'(THIRD);
  assign rel       = XW'(hx) - xs;
  assign in_x      = (XW'(hx) >= xs) && (hx < HX_W'(LINE_W));
  assign u         = rel >> wshift(row_mode);
  assign col       = u / XW'(CELL_W);
  assign gx        = u - col * XW'(CELL_W);
  assign in_grid   = col < XW'(COLS);
  assign idx       = ADDR_W'(row_idx) * ADDR_W'(COLS) + ADDR_W'(col);
  assign cell_code = (row_hit && in_grid) ? code_mem[idx] : '0;
  assign cell_col  = (row_hit && in_grid) ? colr_mem[idx] : '0;
  assign dy        = vy_x - row_top;
  assign gline     = LINE_BITS'(is_tall(row_mode) ? (dy >> 1) : dy);
  assign act       = row_hit && in_x && in_grid && (cell_code != '0);
  assign font_addr = {cell_code, gline};

  logic            s1_act;
  logic [GX_W-1:0] s1_g;
  logic [2:0]      s1_col;
  logic            lit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= 1'b0;
      s1_g   <= '0;
      s1_col <= '0;
    end else begin
      s1_act <= act;
      s1_g   <= GX_W'(gx);
      s1_col <= cell_col;
    end
  end

  assign lit = s1_act && font_data[GX_W'(CELL_W - 1) - s1_g];

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_color <= '0;
    end else begin
      pix_valid <= lit;
      pix_color <= lit ? s1_col : 3'd0;
    end
  end
endmodule

// File: rtl/osd_gen_chk.sv
module osd_gen_chk #(
  parameter int LINE_W = 720,
  parameter int HX_W   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [HX_W-1:0] hx,
  input logic            code_zero,
  input logic            pix_valid,
  input logic [2:0]      pix_color
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!pix_valid && pix_color == 3'd0));

  // R3
  hx_bound_chk: assert property (@(posedge clk) disable iff (rst) hx <= HX_W'(LINE_W));

  // R4
  colour_dark_chk: assert property (@(posedge clk) disable iff (rst) !pix_valid |-> pix_color == 3'd0);

  // R5
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst) code_zero |-> ##2 !pix_valid);

  // R10
  clip_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (hx >= HX_W'(LINE_W)) |-> ##2 !pix_valid);
endmodule

bind osd_gen osd_gen_chk #(.LINE_W(LINE_W), .HX_W(HX_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .hx(hx),
  .code_zero(cell_code == '0),
  .pix_valid(pix_valid),
  .pix_color(pix_color)
);

// File: tb/osd_gen_test.sv
module osd_gen_test;
  localparam int LW = 720;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync = 1'b0, vsync = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [8:0]  wr_addr = '0;
  logic [16:0] wr_data = '0;
  logic [18:0] font_addr;
  logic [23:0] font_data;
  logic        pix_valid;
  logic [2:0]  pix_color;

  int vectors = 0, miscompares = 0;
  int sh_code [288];
  int sh_col  [288];
  int sh_mode [12];
  int sh_hpos = 0, sh_vst = 0, sh_gap = 0;

  always #2 clk = ~clk;

  function automatic logic [23:0] glyph(input logic [18:0] a);
    logic [31:0] p;
    p = {13'd0, a} * 32'h9E3779B1;
    return p[27:4] ^ {a[4:0], a};
  endfunction

  always @(posedge clk) font_data <= glyph(font_addr);

  osd_gen uut (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
    .font_addr(font_addr), .font_data(font_data),
    .pix_valid(pix_valid), .pix_color(pix_color)
  );

  function automatic int tall(input int m);
    return (m == 2 || m == 3 || m == 4) ? 1 : 0;
  endfunction

  task automatic expect_pix(input int x, input int L, output logic v, output logic [2:0] c);
    int top, rtop, found, h, xs, wm, u, cl, g, idx, gl;
    logic [23:0] d;
    v = 1'b0; c = 3'd0; top = sh_vst; found = -1; rtop = 0;
    for (int r = 0; r < 12; r++) begin
      h = tall(sh_mode[r]) ? 64 : 32;
      if (found < 0 && L >= top && L < top + h) begin found = r; rtop = top; end
      top = top + h + sh_gap;
    end
    if (found < 0 || x >= LW) return;
    xs = sh_hpos * 8;
    if (x < xs) return;
    wm = (sh_mode[found] == 1 || sh_mode[found] == 3) ? 2 : (sh_mode[found] == 4) ? 4 : 1;
    u = (x - xs) / wm;
    cl = u / 24;
    if (cl >= 24) return;
    g = u % 24;
    idx = found * 24 + cl;
    if (sh_code[idx] == 0) return;
    gl = (L - rtop) / (tall(sh_mode[found]) ? 2 : 1);
    d = glyph({14'(sh_code[idx]), 5'(gl)});
    if (d[23 - g]) begin v = 1'b1; c = 3'(sh_col[idx]); end
  endtask

  task automatic check(input string req, input int L, input int x,
                       input logic gv, input logic [2:0] gc, input logic ev, input logic [2:0] ec);
    vectors++;
    if (gv !== ev || gc !== ec) begin
      miscompares++;
      $display("FAIL %s line %0d dot %0d: valid=%0b colour=%0d, expected valid=%0b colour=%0d",
               req, L, x, gv, gc, ev, ec);
    end
  endtask

  task automatic wr(input int kind, input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_addr = 9'(addr); wr_data = 17'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic scan_line(input string req, input int L, input logic both);
    logic ev; logic [2:0] ec;
    @(negedge clk); hsync = 1'b1; vsync = both;
    @(negedge clk); hsync = 1'b0; vsync = 1'b0;
    @(negedge clk);
    for (int x = 0; x < LW + 4; x++) begin
      @(negedge clk);
      expect_pix(x, L, ev, ec);
      check(req, L, x, pix_valid, pix_color, ev, ec);
    end
  endtask

  task automatic line(input string req, input int L);
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    for (int i = 0; i < L; i++) begin
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
    end
    scan_line(req, L, 1'b0);
  endtask

  task automatic load(input int hp, input int vs, input int gp, input logic mixed);
    for (int i = 0; i < 288; i++) begin
      sh_code[i] = (i % 13 == 4) ? 0 : ((i * 613 + 11) % 16384);
      sh_col[i]  = (i * 5 + 1) % 8;
      wr(0, i, (sh_col[i] << 14) | sh_code[i]);
    end
    for (int r = 0; r < 12; r++) begin
      sh_mode[r] = !mixed ? 0 : (r < 5) ? r : (r == 5) ? 7 : 0;
      wr(1, r, sh_mode[r]);
    end
    sh_hpos = hp; wr(2, 0, hp);
    sh_vst = vs; sh_gap = gp; wr(3, 0, (gp << 10) | vs);
  endtask

  task automatic t_reset;
    vectors++;
    if (pix_valid !== 1'b0 || pix_color !== 3'd0) begin
      miscompares++;
      $display("FAIL R1 outputs in reset: valid=%0b colour=%0d, expected 0 0", pix_valid, pix_color);
    end
    @(negedge clk); rst = 1'b0;
    line("R1", 5);
  endtask

  task automatic t_standard;
    load(5, 3, 2, 1'b1);
    line("R3", 3);
    line("R4", 20);
    line("R5", 34);
    line("R2", 504);
  endtask

  task automatic t_width;
    line("R6", 37);
    line("R6", 68);
    line("R6", 275);
  endtask

  task automatic t_height;
    line("R7", 71);
    line("R7", 72);
    line("R7", 160);
    line("R7", 230);
  endtask

  task automatic t_vertical;
    line("R9", 0);
    line("R9", 35);
    line("R9", 36);
    line("R9", 473);
    line("R9", 505);
  endtask

  task automatic t_clip;
    line("R10", 203);
    line("R10", 266);
  endtask

  task automatic t_hpos;
    load(1, 0, 0, 1'b0);
    line("R8", 10);
    line("R9", 31);
    line("R9", 32);
    line("R9", 383);
  endtask

  task automatic t_strobes;
    scan_line("R11", 0, 1'b1);
    line("R11", 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 288; i++) begin sh_code[i] = 0; sh_col[i] = 0; end
    for (int r = 0; r < 12; r++) sh_mode[r] = 0;
    repeat (3) @(negedge clk);
    t_reset;
    t_standard;
    t_width;
    t_height;
    t_vertical;
    t_clip;
    t_hpos;
    t_strobes;
    finish_run;
  end

  initial begin
    #(4 * 195000);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run;
  end
endmodule